// File: doc/BRIEF.md
# Dual-Axis Host Register Port

This block sits between an 8-bit host bus and two identical counter channels, X and Y. The host drives an active-low chip select, read and write strobes, a control/data select and an axis select. The block brings these asynchronous pins into the system clock domain through a two-flop synchronizer. It then detects the trailing edge of each strobe and turns each completed write into a one-cycle control-register or data-register write strobe for the addressed channel.

Each channel holds a wide value that moves as a sequence of bytes, least significant byte first. The block keeps a byte pointer for each channel. Any control write that reaches a channel resets that channel's pointer. Each completed data write or data read advances the pointer. On reads the block combinationally selects the addressed channel's flag byte, or the output-latch byte at that channel's pointer, and drives it onto the data bus with an output enable for an external three-state pad. A control write with its top data bit set goes to both channels, whatever the axis select line says.

Top module: `dual_axis_host_port`

## Requirements
- R1: While rst_ni is low, and after its release until a host access completes, ctl_we_o and dat_we_o are 0, both byte pointers are 0, wdata_o and widx_o are 0.
- R2: data_oe_o is 1 exactly while cs_ni and rd_ni are both 0. data_o is 0 whenever data_oe_o is 0.
- R3: A read with cd_i = 1 drives the flag byte of the channel chosen by axis_i (0 = X = flag_i[7:0], 1 = Y = flag_i[15:8]).
- R4: A read with cd_i = 0 drives byte p of the chosen channel's latch word, where p is that channel's pointer and byte 0 is the word's bits 7:0 (X word latch_i[23:0], Y word latch_i[47:24]).
- R5: A write completes when wr_ni rises while cs_ni is 0. The resulting strobe is high for exactly one clock cycle and first appears after the second rising clock edge that follows the first edge sampling wr_ni high. cs_ni, cd_i, axis_i and data_i are taken from that same sample. wdata_o holds that write's data until the next write.
- R6: A completed write with cd_i = 1 and data bit 7 = 0 pulses ctl_we_o bit axis_i only (bit 0 = X, bit 1 = Y).
- R7: A completed write with cd_i = 1 and data bit 7 = 1 pulses both ctl_we_o bits, regardless of axis_i.
- R8: A completed write with cd_i = 0 pulses dat_we_o bit axis_i. widx_o gives that channel's pointer before the access. The pointer then advances by one and wraps from 2 to 0.
- R9: A data read completes when rd_ni rises while cs_ni is 0 and cd_i is 0. It advances the addressed channel's pointer, visible on the same edge a write strobe would be. A flag read (cd_i = 1) leaves the pointers unchanged.
- R10: A control write clears the pointer of every channel it targets and leaves any other channel's pointer unchanged.
- R11: Strobe edges while cs_ni is 1 produce no write strobe, leave both pointers unchanged and leave data_oe_o at 0.
- R12: The two pointers advance independently: an access to one channel never moves the other channel's pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, captured on its rising edge |
| cd_i | input | 1 | 1 = control register, 0 = data register |
| axis_i | input | 1 | 0 = X channel, 1 = Y channel |
| data_i | input | 8 | Host write data |
| flag_i | input | 16 | Flag bytes, X in the low byte |
| latch_i | input | 48 | Output-latch words, X in the low 24 bits |
| data_o | output | 8 | Read data toward the three-state pad |
| data_oe_o | output | 1 | Pad output enable |
| ctl_we_o | output | 2 | Control-register write strobe per channel |
| dat_we_o | output | 2 | Data-register write strobe per channel |
| wdata_o | output | 8 | Data of the last completed write |
| widx_o | output | 2 | Byte index of the last data write |

## Verification
The bench builds the block with its defaults: 8-bit bytes, three bytes per channel word and a two-stage synchronizer. With these values a fourth data access to one channel exposes the pointer wrap back to byte 0. The short three-cycle pipeline also lets a behavioural model predict every strobe edge exactly. Directed sequences mix flag reads, wrapping data reads and writes on both channels, single-axis and broadcast control writes, and strobes with chip select high. The model follows each pointer separately, so any disturbance of the other channel's pointer shows up on the next latch read.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
  localparam int SYNC_DEPTH = 2;
  localparam int N_CH       = 2;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic cd;
    logic axis;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, cd: 1'b0, axis: 1'b0};
endpackage

// File: rtl/hostif_sync.sv
module hostif_sync #(
  parameter int           W      = 1,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/hostif_decode.sv
module hostif_decode
  import hostif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_evt_o,
  output logic [N_CH-1:0]   ctl_hit_o,
  output logic [N_CH-1:0]   dwr_hit_o,
  output logic [N_CH-1:0]   drd_hit_o
);
  logic wr_prev_q, rd_prev_q;
  logic wr_rise, rd_rise;
  logic [N_CH-1:0] ax_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= ctl_i.wr_n;
      rd_prev_q <= ctl_i.rd_n;
    end
  end

  // Trailing edge of each strobe, qualified by the select sampled with it
  assign wr_rise = ctl_i.wr_n & ~wr_prev_q & ~ctl_i.cs_n;
  assign rd_rise = ctl_i.rd_n & ~rd_prev_q & ~ctl_i.cs_n & ~ctl_i.cd & ~wr_rise;
  assign ax_mask = N_CH'(1) << ctl_i.axis;

  always_comb begin
    ctl_hit_o = '0;
    dwr_hit_o = '0;
    drd_hit_o = '0;
    if (wr_rise) begin
      if (ctl_i.cd) ctl_hit_o = data_i[DATA_W-1] ? '1 : ax_mask;
      else          dwr_hit_o = ax_mask;
    end
    if (rd_rise) drd_hit_o = ax_mask;
  end

  assign wr_evt_o = wr_rise;
endmodule

// File: rtl/hostif_ptr.sv
module hostif_ptr #(
  parameter int CNT_BYTES = 3,
  parameter int PTR_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(CNT_BYTES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clr_i)   ptr_o <= '0;
    else if (adv_i)   ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/hostif_rdmux.sv
module hostif_rdmux
  import hostif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_BYTES = 3,
  parameter int PTR_W     = 2,
  localparam int CNT_W    = DATA_W * CNT_BYTES
) (
  input  logic                         cs_ni,
  input  logic                         rd_ni,
  input  logic                         cd_i,
  input  logic                         axis_i,
  input  logic [N_CH*DATA_W-1:0]       flag_i,
  input  logic [N_CH*CNT_W-1:0]        latch_i,
  input  logic [N_CH-1:0][PTR_W-1:0]   ptr_i,
  output logic [DATA_W-1:0]            data_o,
  output logic                         oe_o
);
  logic [CNT_W-1:0]  word_sel;
  logic [DATA_W-1:0] flag_sel, byte_sel;
  logic [PTR_W-1:0]  ptr_sel;

  always_comb begin
    word_sel = latch_i[CNT_W-1:0];
    flag_sel = flag_i[DATA_W-1:0];
    ptr_sel  = ptr_i[0];
    for (int c = 1; c < N_CH; c++) begin
      if (int'(axis_i) == c) begin
        word_sel = latch_i[c*CNT_W +: CNT_W];
        flag_sel = flag_i[c*DATA_W +: DATA_W];
        ptr_sel  = ptr_i[c];
      end
    end
    byte_sel = '0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (int'(ptr_sel) == b) byte_sel = word_sel[b*DATA_W +: DATA_W];
    end
  end

  assign oe_o   = ~cs_ni & ~rd_ni;
  assign data_o = oe_o ? (cd_i ? flag_sel : byte_sel) : '0;
endmodule

// File: rtl/dual_axis_host_port.sv
module dual_axis_host_port
  import hostif_pkg::*;
#(
  parameter int  DATA_W    = 8,
  parameter int  CNT_BYTES = 3,
  localparam int CNT_W     = DATA_W * CNT_BYTES,
  localparam int PTR_W     = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   rd_ni,
  input  logic                   wr_ni,
  input  logic                   cd_i,
  input  logic                   axis_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic [2*DATA_W-1:0]    flag_i,
  input  logic [2*CNT_W-1:0]     latch_i,
  output logic [DATA_W-1:0]      data_o,
  output logic                   data_oe_o,
  output logic [1:0]             ctl_we_o,
  output logic [1:0]             dat_we_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic [PTR_W-1:0]       widx_o
);
  bus_ctl_t            ctl_raw, ctl_s;
  logic [DATA_W-1:0]   data_s;
  logic                wr_evt;
  logic [N_CH-1:0]     ctl_hit, dwr_hit, drd_hit;
  logic [N_CH-1:0][PTR_W-1:0] ptr;

  assign ctl_raw = '{cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni, cd: cd_i, axis: axis_i};

  hostif_sync #(.W($bits(bus_ctl_t)), .STAGES(SYNC_DEPTH), .RST(CTL_IDLE)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i(ctl_raw), .q_o(ctl_s)
  );

  hostif_sync #(.W(DATA_W), .STAGES(SYNC_DEPTH), .RST('0)) u_sync_dat (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s)
  );

  hostif_decode #(.DATA_W(DATA_W)) u_dec (
    .clk_i, .rst_ni, .ctl_i(ctl_s), .data_i(data_s), .wr_evt_o(wr_evt),
    .ctl_hit_o(ctl_hit), .dwr_hit_o(dwr_hit), .drd_hit_o(drd_hit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    hostif_ptr #(.CNT_BYTES(CNT_BYTES), .PTR_W(PTR_W)) u_ptr (
      .clk_i, .rst_ni,
      .clr_i(ctl_hit[c]),
      .adv_i(dwr_hit[c] | drd_hit[c]),
      .ptr_o(ptr[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_we_o <= '0;
      dat_we_o <= '0;
      wdata_o  <= '0;
      widx_o   <= '0;
    end else begin
      ctl_we_o <= ctl_hit;
      dat_we_o <= dwr_hit;
      if (wr_evt) wdata_o <= data_s;
      if (|dwr_hit) widx_o <= ptr[ctl_s.axis];
    end
  end

  hostif_rdmux #(.DATA_W(DATA_W), .CNT_BYTES(CNT_BYTES), .PTR_W(PTR_W)) u_rd (
    .cs_ni, .rd_ni, .cd_i, .axis_i, .flag_i, .latch_i, .ptr_i(ptr),
    .data_o, .oe_o(data_oe_o)
  );
endmodule

// File: rtl/hostif_chk.sv
module hostif_chk #(
  parameter int DATA_W    = 8,
  parameter int CNT_BYTES = 3,
  parameter int PTR_W     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              wr_ni,
  input logic              cd_i,
  input logic              axis_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [1:0]        ctl_we_o,
  input logic [1:0]        dat_we_o,
  input logic [PTR_W-1:0]  widx_o
);
  p_idle_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ctl_we_o || |dat_we_o) |=> (ctl_we_o == '0 && dat_we_o == '0));

  p_write_origin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ctl_we_o || |dat_we_o) |-> (!$past(cs_ni, 3) && $past(wr_ni, 3) && !$past(wr_ni, 4)));

  p_one_kind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|ctl_we_o && |dat_we_o));

  p_ctl_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ctl_we_o) |-> ($past(cd_i, 3) && !$past(data_i[DATA_W-1], 3) &&
                           ctl_we_o[$past(axis_i, 3)]));

  p_broadcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_o == 2'b11) |-> ($past(cd_i, 3) && $past(data_i[DATA_W-1], 3)));

  p_dat_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |dat_we_o |-> ($onehot(dat_we_o) && !$past(cd_i, 3) && dat_we_o[$past(axis_i, 3)]));

  p_idx_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |dat_we_o |-> int'(widx_o) < CNT_BYTES);
endmodule

bind dual_axis_host_port hostif_chk #(.DATA_W(DATA_W), .CNT_BYTES(CNT_BYTES), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_ni(wr_ni), .cd_i(cd_i),
  .axis_i(axis_i), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
  .ctl_we_o(ctl_we_o), .dat_we_o(dat_we_o), .widx_o(widx_o)
);

// File: tb/sim_dual_axis_host_port.sv
`timescale 1ns/1ps
module sim_dual_axis_host_port;
  localparam int DW = 8;
  localparam int NB = 3;
  localparam int CW = DW * NB;
  localparam int LAT = 2;   // synchronizer depth seen by the model

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0, ax = 1'b0;
  logic [DW-1:0] din = '0;
  logic [2*DW-1:0] flag = 16'hC65A;
  logic [2*CW-1:0] latch = {24'h1D2E3F, 24'hA1B2C3};
  logic [DW-1:0] dout, wdata;
  logic oe;
  logic [1:0] ctl_we, dat_we, widx;

  always #10 clk = ~clk;

  dual_axis_host_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .cd_i(cd), .axis_i(ax), .data_i(din), .flag_i(flag), .latch_i(latch),
    .data_o(dout), .data_oe_o(oe), .ctl_we_o(ctl_we), .dat_we_o(dat_we),
    .wdata_o(wdata), .widx_o(widx)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  // snapshot: cs_n rd_n wr_n cd ax data
  typedef struct packed { logic cs_n, rd_n, wr_n, cd, ax; logic [DW-1:0] d; } snap_t;
  localparam snap_t IDLE = '{cs_n:1, rd_n:1, wr_n:1, cd:0, ax:0, d:0};
  snap_t hist [0:LAT+1];
  int ptr [2];
  logic [1:0] e_ctl, e_dat;
  logic [DW-1:0] e_wdata;
  int e_widx;

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h at %0t", phase, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= LAT + 1; i++) hist[i] = IDLE;
      ptr[0] = 0; ptr[1] = 0;
      e_ctl = '0; e_dat = '0; e_wdata = '0; e_widx = 0;
    end else begin
      snap_t n, o;
      for (int i = LAT + 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = '{cs_n:cs_n, rd_n:rd_n, wr_n:wr_n, cd:cd, ax:ax, d:din};
      n = hist[LAT]; o = hist[LAT+1];
      e_ctl = '0; e_dat = '0;
      if (n.wr_n && !o.wr_n && !n.cs_n) begin
        e_wdata = n.d;
        if (n.cd) begin
          e_ctl = n.d[DW-1] ? 2'b11 : (2'b01 << n.ax);
          for (int c = 0; c < 2; c++) if (e_ctl[c]) ptr[c] = 0;
        end else begin
          e_dat = 2'b01 << n.ax;
          e_widx = ptr[n.ax];
          ptr[n.ax] = (ptr[n.ax] + 1) % NB;
        end
      end else if (n.rd_n && !o.rd_n && !n.cs_n && !n.cd) begin
        ptr[n.ax] = (ptr[n.ax] + 1) % NB;
      end
    end
    #5;
    if (!done) begin
      logic exp_oe;
      logic [DW-1:0] exp_d;
      exp_oe = !cs_n && !rd_n;
      exp_d = '0;
      if (exp_oe) exp_d = cd ? flag[ax*DW +: DW] : latch[ax*CW + ptr[ax]*DW +: DW];
      chk("R2 data_oe_o", oe, exp_oe);
      chk(cd ? "R3 data_o flag" : "R4 data_o latch", dout, exp_d);
      chk("R6 R7 ctl_we_o", ctl_we, e_ctl);
      chk("R8 dat_we_o", dat_we, e_dat);
      chk("R5 wdata_o", wdata, e_wdata);
      chk("R8 widx_o", widx, e_widx);
    end
  end

  task automatic wr_acc(input logic c, input logic a, input logic [DW-1:0] d, input logic sel_n = 1'b0);
    @(negedge clk); cs_n = sel_n; cd = c; ax = a; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1;
    repeat (5) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_acc(input logic c, input logic a, input logic sel_n = 1'b0);
    @(negedge clk); cs_n = sel_n; cd = c; ax = a; rd_n = 1'b0;
    repeat (3) @(negedge clk); rd_n = 1'b1;
    repeat (5) @(negedge clk); cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R3 flag reads";      rd_acc(1, 0); rd_acc(1, 1);
    phase = "R4 R9 X wrap";       repeat (4) rd_acc(0, 0);
    phase = "R12 Y independent";  rd_acc(0, 1);
    phase = "R6 ctl X";           wr_acc(1, 0, 8'h05);
    phase = "R10 ctl Y";          wr_acc(1, 1, 8'h11);
    phase = "R8 data writes Y";   wr_acc(0, 1, 8'h3C); wr_acc(0, 1, 8'h4D);
                                  wr_acc(0, 1, 8'h5E); wr_acc(0, 1, 8'h6F);
    phase = "R12 X after Y";      rd_acc(0, 0);
    phase = "R8 data write X";    wr_acc(0, 0, 8'h77);
    phase = "R7 broadcast";       wr_acc(1, 0, 8'h80);
                                  rd_acc(0, 0); rd_acc(0, 1);
    phase = "R10 single clear";   rd_acc(0, 1); wr_acc(1, 0, 8'h02);
                                  rd_acc(0, 1); rd_acc(0, 0);
    phase = "R11 deselected";     wr_acc(1, 1, 8'h81, 1'b1); wr_acc(0, 0, 8'h99, 1'b1);
                                  rd_acc(0, 0, 1'b1); rd_acc(0, 0);
    phase = "R1 reset";           @(negedge clk); rst_n = 1'b0;
                                  repeat (3) @(negedge clk); rst_n = 1'b1;
                                  rd_acc(0, 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule